// File: doc/BRIEF.md
# Banked Interrupt Controller with Round-Robin Next-Source Search

This block collects 128 interrupt sources and arranges them in four banks of 32. Each bank keeps three kinds of state, each one bit per source: sticky pending flags, enable bits and routing bits. A pending source that is enabled raises one of two processor lines. A routing bit of 0 sends it to the normal line, and a routing bit of 1 sends it to the fast line. Software reaches everything through a simple 32-bit register port with separate read and write strobes. Each bank takes a 16-byte window. Inside the window, the words are, in order: pending (read), clear (write ones to drop flags), enable, and route.

Past the bank windows there are two more registers. The first is a "next source" register. Reading it returns the first pending source found in a circular search that starts one past the index serviced last. It returns a valid flag of 0 when nothing is pending. When a read of this register reports a source, that index becomes the new "last serviced" value, so repeated reads walk fairly through all busy sources. The second register holds the last-serviced index, and software can also read and write it directly. A parameter selects whether a source is captured on its rising edge or while it is high.

Top module: `banked_irq_ctrl`

## Requirements
- R1: With the default edge capture, a 0-to-1 change of `src_i[n]` seen at a clock edge sets pending bit n at that edge. The bit stays set after the source falls, until software clears it. Source n lives in bank n/32, bit n%32.
- R2: A write to a bank's clear word (bank base + 4) drops every pending bit written as 1 and leaves bits written as 0 unchanged. Writing all ones empties the bank.
- R3: If a new rising edge on a source lands in the same cycle as a clear of its bit, the pending bit remains set.
- R4: After reset, all pending, enable and route bits read 0. The enable word (base + 8) and the route word (base + 12) read back the value last written. The pending word is at base + 0, and a read of the clear word returns 0.
- R5: `irq_o` is registered. In each cycle it equals the OR, taken over all sources as they stood in the previous cycle, of pending AND enable AND NOT route.
- R6: `fiq_o` is registered. In each cycle it equals the OR, taken over all sources as they stood in the previous cycle, of pending AND enable AND route.
- R7: A read at byte offset 0x40 returns the valid flag in bit 31 and the source index in bits 6:0, and all other bits are 0. The search begins at (last+1) mod 128, wraps around, and looks at raw pending bits. When no bit is pending it returns 0.
- R8: A read of offset 0x40 that finds a source loads that index into the last-serviced register. A read that finds none leaves the register unchanged.
- R9: The last-serviced register at offset 0x44 resets to 127, so the first search begins at source 0. Software can write and read its bits 6:0.
- R10: Reads of any offset outside the map return 0, and writes to such offsets change no state. Outside the map means any offset that is not word-aligned, and any offset above 0x44.
- R11: Read data is registered: `rdata_o` shows the addressed value in the cycle after `rd_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 128 | Interrupt source lines |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the read strobe |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The delicate collision is a software clear of a bank landing in the same cycle as a fresh rising edge on a source that the clear mask covers. In that case the new event must win, and any other bit written as 1 must still drop. The bench provokes the collision in a directed step that raises a source and clears its bit together. The random phase, with dense source toggling and frequent clear writes, provokes it many more times. A second overlap is a next-source read that moves the last-serviced index while the pending bits are changing underneath it. Both cases are judged against a cycle-accurate model in the bench: every readback and both interrupt lines are compared with it each cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Word slot inside a bank window (address bits 3:2)
  typedef enum logic [1:0] {
    SLOT_PEND  = 2'd0,
    SLOT_CLR   = 2'd1,
    SLOT_EN    = 2'd2,
    SLOT_ROUTE = 2'd3
  } bank_slot_e;

  localparam int BUS_W        = 32;
  localparam int BANK_SPAN_B  = 16;
endpackage

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int W         = 32,
  parameter bit EDGE_MODE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src,
  input  logic         wr_clr,
  input  logic         wr_en_mask,
  input  logic         wr_route,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pend,
  output logic [W-1:0] enable,
  output logic [W-1:0] route
);
  logic [W-1:0] set_v;
  logic [W-1:0] clr_v;

  generate
    if (EDGE_MODE) begin : g_edge
      logic [W-1:0] src_q;
      always_ff @(posedge clk) begin
        if (rst) src_q <= '0;
        else     src_q <= src;
      end
      assign set_v = src & ~src_q;
    end else begin : g_level
      assign set_v = src;
    end
  endgenerate

  assign clr_v = wr_clr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= '0;
      enable <= '0;
      route  <= '0;
    end else begin
      // a fresh event outranks a clear in the same cycle
      pend <= (pend & ~clr_v) | set_v;
      if (wr_en_mask) enable <= wdata;
      if (wr_route)   route  <= wdata;
    end
  end
endmodule

// File: rtl/irqc_rr_pick.sv
module irqc_rr_pick #(
  parameter int N     = 128,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     pend,
  input  logic [IDX_W-1:0] last,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);
  // N is a power of two, so index arithmetic wraps on its own
  always_comb begin
    logic [IDX_W-1:0] pos;
    valid = 1'b0;
    idx   = '0;
    for (int i = 1; i <= N; i++) begin
      pos = last + IDX_W'(i);
      if (!valid && pend[pos]) begin
        valid = 1'b1;
        idx   = pos;
      end
    end
  end
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 8,
  parameter bit EDGE_MODE = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_BANKS*BANK_W-1:0] src_i,
  input  logic                     wr_en_i,
  input  logic                     rd_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [31:0]              wdata_i,
  output logic [31:0]              rdata_o,
  output logic                     irq_o,
  output logic                     fiq_o
);
  import irqc_pkg::*;

  localparam int NSRC    = NUM_BANKS * BANK_W;
  localparam int IDX_W   = $clog2(NSRC);
  localparam int BSEL_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int MAP_END = BANK_SPAN_B * NUM_BANKS;
  localparam logic [ADDR_W-1:0] A_BANK_END = ADDR_W'(MAP_END);
  localparam logic [ADDR_W-1:0] A_NEXT     = ADDR_W'(MAP_END);
  localparam logic [ADDR_W-1:0] A_LAST     = ADDR_W'(MAP_END + 4);

  logic [BANK_W-1:0] pend_b  [NUM_BANKS];
  logic [BANK_W-1:0] en_b    [NUM_BANKS];
  logic [BANK_W-1:0] route_b [NUM_BANKS];
  logic [NSRC-1:0]   pend_all, en_all, route_all;

  logic              in_banks;
  logic [BSEL_W-1:0] bank_sel;
  bank_slot_e        slot;
  logic              clr_any;
  logic [IDX_W-1:0]  last_q;
  logic              pick_valid;
  logic [IDX_W-1:0]  pick_idx;
  logic [31:0]       rd_val;

  assign in_banks = (addr_i < A_BANK_END) && (addr_i[1:0] == 2'b00);
  assign bank_sel = BSEL_W'(addr_i >> 4);
  assign slot     = bank_slot_e'(addr_i[3:2]);
  assign clr_any  = wr_en_i && in_banks && (slot == SLOT_CLR);

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit;
      assign hit = wr_en_i && in_banks && (bank_sel == BSEL_W'(b));
      irqc_bank #(.W(BANK_W), .EDGE_MODE(EDGE_MODE)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .src        (src_i[b*BANK_W +: BANK_W]),
        .wr_clr     (hit && (slot == SLOT_CLR)),
        .wr_en_mask (hit && (slot == SLOT_EN)),
        .wr_route   (hit && (slot == SLOT_ROUTE)),
        .wdata      (wdata_i[BANK_W-1:0]),
        .pend       (pend_b[b]),
        .enable     (en_b[b]),
        .route      (route_b[b])
      );
      assign pend_all[b*BANK_W +: BANK_W]  = pend_b[b];
      assign en_all[b*BANK_W +: BANK_W]    = en_b[b];
      assign route_all[b*BANK_W +: BANK_W] = route_b[b];
    end
  endgenerate

  irqc_rr_pick #(.N(NSRC), .IDX_W(IDX_W)) u_pick (
    .pend  (pend_all),
    .last  (last_q),
    .valid (pick_valid),
    .idx   (pick_idx)
  );

  always_comb begin
    rd_val = '0;
    if (in_banks) begin
      case (slot)
        SLOT_PEND:  rd_val = 32'(pend_b[bank_sel]);
        SLOT_EN:    rd_val = 32'(en_b[bank_sel]);
        SLOT_ROUTE: rd_val = 32'(route_b[bank_sel]);
        default:    rd_val = '0;
      endcase
    end else if (addr_i == A_NEXT) begin
      rd_val = {pick_valid, {(31-IDX_W){1'b0}}, pick_idx};
    end else if (addr_i == A_LAST) begin
      rd_val = 32'(last_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q  <= '1;
      rdata_o <= '0;
      irq_o   <= 1'b0;
      fiq_o   <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == A_LAST)
        last_q <= wdata_i[IDX_W-1:0];
      else if (rd_en_i && addr_i == A_NEXT && pick_valid)
        last_q <= pick_idx;
      if (rd_en_i) rdata_o <= rd_val;
      irq_o <= |(pend_all & en_all & ~route_all);
      fiq_o <= |(pend_all & en_all & route_all);
    end
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NSRC    = 128,
  parameter int IDX_W   = 7,
  parameter int ADDR_W  = 8,
  parameter int MAP_END = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       rdata_o,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [NSRC-1:0]   pend_all,
  input logic [NSRC-1:0]   en_all,
  input logic [NSRC-1:0]   route_all,
  input logic              clr_any,
  input logic [IDX_W-1:0]  last_q,
  input logic              pick_valid,
  input logic [IDX_W-1:0]  pick_idx
);
  logic unmapped;
  logic next_rd;
  assign unmapped = (addr_i[1:0] != 2'b00) || (addr_i > ADDR_W'(MAP_END + 4));
  assign next_rd  = rd_en_i && (addr_i == ADDR_W'(MAP_END));

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    !$past(clr_any) |-> (($past(pend_all) & ~pend_all) == '0)); // R1

  AST_EN_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en_all == '0 && route_all == '0)); // R4

  AST_IRQ_LINE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq_o == $past(|(pend_all & en_all & ~route_all))); // R5

  AST_FIQ_LINE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> fiq_o == $past(|(pend_all & en_all & route_all))); // R6

  AST_LAST_LOAD: assert property (@(posedge clk) disable iff (rst)
    $past(next_rd && pick_valid) |-> last_q == $past(pick_idx)); // R8

  AST_NONE_KEEP: assert property (@(posedge clk) disable iff (rst)
    $past(next_rd && !pick_valid) |-> $stable(last_q)); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en_i && unmapped) |-> rdata_o == '0); // R10
endmodule

bind banked_irq_ctrl irqc_checker #(
  .NSRC(NSRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .MAP_END(MAP_END)
) u_chk (
  .clk(clk), .rst(rst), .rd_en_i(rd_en_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .irq_o(irq_o), .fiq_o(fiq_o),
  .pend_all(pend_all), .en_all(en_all), .route_all(route_all),
  .clr_any(clr_any), .last_q(last_q),
  .pick_valid(pick_valid), .pick_idx(pick_idx)
);

// File: tb/banked_irq_ctrl_bench.sv
module banked_irq_ctrl_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] src = '0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         irq_o, fiq_o;

  int checks = 0;
  int errors = 0;

  // model state
  logic [127:0] m_pend, m_en, m_route, m_srcq;
  logic [6:0]   m_last;

  always #4 clk = ~clk;

  banked_irq_ctrl u_banked_irq_ctrl (
    .clk(clk), .rst(rst), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_pick();
    for (int i = 1; i <= 128; i++) begin
      logic [6:0] p;
      p = m_last + 7'(i);
      if (m_pend[p]) return {1'b1, 24'd0, p};
    end
    return 32'd0;
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    int b;
    b = a[5:4];
    if (a < 8'h40 && a[1:0] == 2'b00) begin
      case (a[3:2])
        2'd0: return m_pend[b*32 +: 32];
        2'd2: return m_en[b*32 +: 32];
        2'd3: return m_route[b*32 +: 32];
        default: return 32'd0;
      endcase
    end
    if (a == 8'h40) return model_pick();
    if (a == 8'h44) return {25'd0, m_last};
    return 32'd0;
  endfunction

  // one clock of stimulus; model advances alongside, outputs checked after
  task automatic step(input logic [127:0] s, input logic we, input logic re,
                      input logic [7:0] a, input logic [31:0] d, input string tag);
    logic [31:0]  exp_rd, pk;
    logic         e_irq, e_fiq;
    logic [127:0] clrv;
    int b;
    src = s; wr_en = we; rd_en = re; addr = a; wdata = d;
    exp_rd = model_read(a);
    pk     = model_pick();
    e_irq  = |(m_pend & m_en & ~m_route);
    e_fiq  = |(m_pend & m_en & m_route);
    clrv   = '0;
    b      = a[5:4];
    if (we && a < 8'h40 && a[1:0] == 2'b00) begin
      if (a[3:2] == 2'd1) clrv[b*32 +: 32] = d;
      if (a[3:2] == 2'd2) m_en[b*32 +: 32] = d;
      if (a[3:2] == 2'd3) m_route[b*32 +: 32] = d;
    end
    m_pend = (m_pend & ~clrv) | (s & ~m_srcq);
    m_srcq = s;
    if (we && a == 8'h44) m_last = d[6:0];
    else if (re && a == 8'h40 && pk[31]) m_last = pk[6:0];
    @(negedge clk);
    chk(irq_o == e_irq, "R5 irq_o", 32'(irq_o), 32'(e_irq));
    chk(fiq_o == e_fiq, "R6 fiq_o", 32'(fiq_o), 32'(e_fiq));
    if (re) chk(rdata == exp_rd, tag, rdata, exp_rd);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic rd(input logic [127:0] s, input logic [7:0] a, input string tag);
    step(s, 1'b0, 1'b1, a, 32'd0, tag);
  endtask

  task automatic wr(input logic [127:0] s, input logic [7:0] a, input logic [31:0] d);
    step(s, 1'b1, 1'b0, a, d, "write");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired R11 actual=%h expected=%h", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    m_pend = '0; m_en = '0; m_route = '0; m_srcq = '0; m_last = 7'd127;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state
    for (int b = 0; b < 4; b++) begin
      rd('0, 8'(16*b + 8), "R4 enable after reset");
      rd('0, 8'(16*b), "R4 pending after reset");
    end
    rd('0, 8'h44, "R9 last resets to 127");
    rd('0, 8'h40, "R7 none pending reads 0");
    rd('0, 8'h44, "R8 empty search keeps last");

    // sticky capture of a pulse on source 5
    step(128'h20, 1'b0, 1'b0, 8'h00, 32'd0, "");
    step('0, 1'b0, 1'b0, 8'h00, 32'd0, "");
    rd('0, 8'h00, "R1 pulse captured and held");
    rd('0, 8'h04, "R4 clear word reads 0");

    // routing to each line
    wr('0, 8'h08, 32'h20);
    step('0, 1'b0, 1'b0, 8'h00, 32'd0, "");
    wr('0, 8'h0C, 32'h20);
    step('0, 1'b0, 1'b0, 8'h00, 32'd0, "");
    rd('0, 8'h0C, "R4 route readback");

    // round-robin search
    rd('0, 8'h40, "R7 finds source 5 from start 0");
    rd('0, 8'h44, "R8 last loaded with 5");
    rd('0, 8'h40, "R7 full wrap back to 5");
    step(128'h8, 1'b0, 1'b0, 8'h00, 32'd0, "");
    rd('0, 8'h40, "R7 wraps past 127 to find 3");
    step(128'h1 << 100, 1'b0, 1'b0, 8'h00, 32'd0, "");
    rd('0, 8'h40, "R7 next after 3 is 5");
    rd('0, 8'h40, "R7 next after 5 is 100");
    wr('0, 8'h44, 32'd99);
    rd('0, 8'h44, "R9 last written");
    rd('0, 8'h40, "R7 from 99 finds 100");

    // same-cycle clear and new edge on source 3; bit 5 dropped
    step('0, 1'b1, 1'b0, 8'h04, 32'h28, "");
    step(128'h8, 1'b1, 1'b0, 8'h04, 32'h28, "");
    rd(128'h8, 8'h00, "R3 edge beats clear");
    wr(128'h8, 8'h04, 32'h0);
    rd(128'h8, 8'h00, "R2 zero bits unchanged");
    wr('0, 8'h34, 32'hFFFF_FFFF);
    wr('0, 8'h04, 32'hFFFF_FFFF);
    rd('0, 8'h00, "R2 all ones empties bank");
    rd('0, 8'h30, "R2 all ones empties bank 3");

    // unmapped accesses
    wr('0, 8'h48, 32'hFFFF_FFFF);
    wr('0, 8'h09, 32'hFFFF_FFFF);
    wr('0, 8'hF8, 32'hFFFF_FFFF);
    rd('0, 8'h08, "R10 misaligned write ignored");
    rd('0, 8'h44, "R10 last untouched");
    rd('0, 8'h48, "R10 unmapped read 0");
    rd('0, 8'h0A, "R10 misaligned read 0");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [127:0] s;
      logic [7:0]   a;
      logic [31:0]  d;
      int op;
      for (int k = 0; k < 4; k++)
        s[k*32 +: 32] = $urandom & $urandom & $urandom;
      op = $urandom_range(0, 9);
      a  = 8'($urandom_range(0, 18) * 4);
      if ($urandom_range(0, 15) == 0) a = 8'($urandom);
      d  = $urandom;
      if ($urandom_range(0, 3) == 0) d = 32'hFFFF_FFFF;
      case (op)
        0, 1: step(s, 1'b0, 1'b1, a, 32'd0, "R11 random read");
        2:    step(s, 1'b0, 1'b1, 8'h40, 32'd0, "R7 random next");
        3:    step(s, 1'b1, 1'b0, 8'(16*$urandom_range(0, 3) + 4), d, "");
        4:    step(s, 1'b1, 1'b0, a, d, "");
        default: step(s, 1'b0, 1'b0, a, d, "");
      endcase
    end
    for (int b = 0; b < 4; b++) rd('0, 8'(16*b), "R1 final pending");
    rd('0, 8'h44, "R8 final last");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule